// File: doc/BRIEF.md
# Fixed-Priority Interrupt Entry Sequencer

This block sits beside a small 16-bit CPU core and decides when and how an interrupt is taken. It holds one pending flag per source and combines each flag with that source's enable. Maskable sources are further gated by the global enable bit of the status register supplied by the core. When the core signals an instruction boundary and at least one request qualifies, the block picks the winner by fixed priority. It saves PC and the status word to a downward-growing stack in memory. It then hands the core a status word with the global enable cleared, together with the vector address to fetch.

On a return command the block reads the saved status word and PC back from the stack and gives them to the core, which also restores the global enable that was in force before entry. After reset the block issues the reset vector and a fixed status word without touching the stack. A handler that sets the global enable again can be interrupted, and each nested entry adds another frame below the previous one. The only limit on nesting is the memory below the stack pointer.

Both stack ports use valid/ready. The write port holds `stk_wr_valid_o`, its address and its data unchanged until `stk_wr_ready_i` is seen high at a clock edge. The read request port does the same with `stk_rd_valid_o` and `stk_rd_ready_i`. The memory answers each accepted read with exactly one `stk_rsp_valid_i` pulse that carries the data, after one or more cycles. The block waits for that pulse and has no ready on the response. Core-side pins are plain pulses: the core is expected to stall while `busy_o` is high.

Top module: `irq_entry_seq`

## Requirements
- R1: A source whose priority index is not a non-maskable one is accepted only when its flag, its enable bit and status bit 3 (global enable) of `cpu_sr_i` are all 1; with bit 3 at 0 its flag stays set and no entry starts.
- R2: A source marked non-maskable (index 30 by default) is accepted with its flag and enable set, whatever the value of status bit 3.
- R3: When several qualified requests are present in the same cycle, the one with the highest index wins; the flags of the losers stay set.
- R4: On entry the PC sampled at acceptance is written to address SP-2, and then the sampled status word is written to SP-4. SP ends 4 lower. While ready is low, valid, address and data of the write port hold.
- R5: After both writes, one cycle carries `vec_fetch_o` with address 0xFFC0 + 2*index and `sr_wr_o` with the sampled status word with bit 3 cleared.
- R6: A return command reads the status word at SP, then the PC at SP+2. SP ends 4 higher, and each value is handed to the core through `sr_wr_o`/`pc_wr_o` in the cycle its response arrives.
- R7: After reset is released, the first action is one `vec_fetch_o` at 0xFFFE with `sr_wr_o` carrying 0, SP at its initial value (0x0200 by default), and no stack write.
- R8: Flags of auto-clearing sources (indices 26 and 30 by default) clear on acceptance; other flags stay set until software clears them. A set and a software clear on the same flag in the same cycle leave it set.
- R9: A return command and a newly qualified request in the same idle cycle: the return runs first, and the request is judged afterwards against the restored state.
- R10: No entry starts while the instruction boundary input is low or while a sequence is running. A maskable request raised inside a handler with bit 3 clear is taken only after the return restores bit 3.
- R11: If a handler sets bit 3 again, a qualified request is accepted and its frame is stacked directly below the current one (SP-4 further down); two returns unwind both frames in reverse order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_set_i | input | NUM_SRC | Per-source event pulses that set flags |
| irq_clr_i | input | NUM_SRC | Per-source software clear pulses |
| irq_en_i | input | NUM_SRC | Per-source enables |
| irq_flags_o | output | NUM_SRC | Pending flags |
| cpu_pc_i | input | W | Current PC of the core |
| cpu_sr_i | input | W | Current status word of the core |
| cpu_boundary_i | input | 1 | Core is at an instruction boundary |
| reti_req_i | input | 1 | Return-from-interrupt command pulse |
| busy_o | output | 1 | Sequence running, core must stall |
| vec_fetch_o | output | 1 | Fetch PC from vector address |
| vec_addr_o | output | W | Vector address |
| sr_wr_o | output | 1 | Load status word into the core |
| sr_wr_data_o | output | W | Status word to load |
| pc_wr_o | output | 1 | Load PC into the core |
| pc_wr_data_o | output | W | PC to load |
| sp_o | output | W | Stack pointer |
| stk_wr_valid_o | output | 1 | Stack write valid |
| stk_wr_ready_i | input | 1 | Stack write ready |
| stk_wr_addr_o | output | W | Stack write address |
| stk_wr_data_o | output | W | Stack write data |
| stk_rd_valid_o | output | 1 | Stack read request valid |
| stk_rd_ready_i | input | 1 | Stack read request ready |
| stk_rd_addr_o | output | W | Stack read address |
| stk_rsp_valid_i | input | 1 | Stack read data valid |
| stk_rsp_data_i | input | W | Stack read data |

## Verification
Two functions can fall into the same cycle here: a return command and the acceptance of a newly qualified request. The bench raises a non-maskable flag one cycle before issuing the return, so both reach the idle state at the same edge. The return must run first. The bench judges this by the order of the observed PC-load and vector events, and by the new frame landing at the top of the stack (0x01FE) instead of below the old one. Set and clear of one flag in the same cycle are also provoked together, and the flag must stay set.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [3:0] {
    S_RST,
    S_IDLE,
    S_PUSH_PC,
    S_PUSH_SR,
    S_VEC,
    S_POP_SR,
    S_WAIT_SR,
    S_POP_PC,
    S_WAIT_PC
  } seq_state_e;

  // bytes per stack slot
  localparam int SLOT_BYTES = 2;

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 31,
  parameter int IW = 5,
  parameter logic [N-1:0] AUTO_CLR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  set_i,
  input  logic [N-1:0]  clr_i,
  input  logic          ack_i,
  input  logic [IW-1:0] ack_idx_i,
  output logic [N-1:0]  flags_o
);

  for (genvar g = 0; g < N; g++) begin : g_flag
    logic take;
    logic flag_q;

    assign take = ack_i && (ack_idx_i == IW'(g)) && AUTO_CLR[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= set_i[g] | (flag_q & ~clr_i[g] & ~take);
    end

    assign flags_o[g] = flag_q;

    // R8: a flag with no clear of any kind stays pending
    a_r8_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr_i[g] && !take) |=> flag_q);

    // R8: a new event always leaves the flag set, even against a clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flag_q);
  end

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int N = 31,
  parameter int IW = 5,
  parameter logic [N-1:0] NMI = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  flags_i,
  input  logic [N-1:0]  en_i,
  input  logic          gie_i,
  output logic          req_any_o,
  output logic [IW-1:0] win_o
);

  logic [N-1:0] req;

  always_comb begin
    req       = flags_i & en_i & (NMI | {N{gie_i}});
    req_any_o = 1'b0;
    win_o     = '0;
    for (int k = 0; k < N; k++) begin
      if (req[k]) begin
        req_any_o = 1'b1;
        win_o     = IW'(k);
      end
    end
  end

  // R3: nothing above the winner is requesting, and the winner is
  a_r3_top_wins: assert property (@(posedge clk) disable iff (!rst_n)
    req_any_o |-> ((flags_i & en_i & (NMI | {N{gie_i}})) >> win_o) == N'(1));

  // R1: with the global enable low only a non-maskable source can win
  a_r1_masked_out: assert property (@(posedge clk) disable iff (!rst_n)
    (req_any_o && !gie_i) |-> NMI[win_o]);

  // R2: an enabled non-maskable flag always yields a request
  a_r2_nmi_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags_i & en_i & NMI)) |-> req_any_o);

endmodule

// File: rtl/irq_stack_fsm.sv
module irq_stack_fsm
  import irq_seq_pkg::*;
#(
  parameter int W = 16,
  parameter int IW = 5,
  parameter int NUM_SRC = 31,
  parameter logic [W-1:0] VEC_BASE = 'hFFC0,
  parameter logic [W-1:0] SP_INIT = 'h0200,
  parameter int GIE_BIT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_any_i,
  input  logic [IW-1:0] win_i,
  output logic          ack_o,
  input  logic [W-1:0]  cpu_pc_i,
  input  logic [W-1:0]  cpu_sr_i,
  input  logic          cpu_boundary_i,
  input  logic          reti_req_i,
  output logic          busy_o,
  output logic          vec_fetch_o,
  output logic [W-1:0]  vec_addr_o,
  output logic          sr_wr_o,
  output logic [W-1:0]  sr_wr_data_o,
  output logic          pc_wr_o,
  output logic [W-1:0]  pc_wr_data_o,
  output logic [W-1:0]  sp_o,
  output logic          stk_wr_valid_o,
  input  logic          stk_wr_ready_i,
  output logic [W-1:0]  stk_wr_addr_o,
  output logic [W-1:0]  stk_wr_data_o,
  output logic          stk_rd_valid_o,
  input  logic          stk_rd_ready_i,
  output logic [W-1:0]  stk_rd_addr_o,
  input  logic          stk_rsp_valid_i,
  input  logic [W-1:0]  stk_rsp_data_i
);

  localparam logic [W-1:0]  STEP    = W'(SLOT_BYTES);
  localparam logic [IW-1:0] RST_IDX = IW'(NUM_SRC);
  localparam logic [W-1:0]  GIE_M   = W'(1) << GIE_BIT;

  seq_state_e    st;
  logic [W-1:0]  sp_q, pc_q, sr_q;
  logic [IW-1:0] idx_q;
  logic [IW-1:0] vec_idx;

  assign ack_o = (st == S_IDLE) && !reti_req_i && cpu_boundary_i && req_any_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_RST;
      sp_q  <= SP_INIT;
      pc_q  <= '0;
      sr_q  <= '0;
      idx_q <= RST_IDX;
    end else begin
      case (st)
        S_RST: st <= S_IDLE;
        S_IDLE: begin
          if (reti_req_i) begin
            st <= S_POP_SR;
          end else if (ack_o) begin
            pc_q  <= cpu_pc_i;
            sr_q  <= cpu_sr_i;
            idx_q <= win_i;
            st    <= S_PUSH_PC;
          end
        end
        S_PUSH_PC: if (stk_wr_ready_i) begin
          sp_q <= sp_q - STEP;
          st   <= S_PUSH_SR;
        end
        S_PUSH_SR: if (stk_wr_ready_i) begin
          sp_q <= sp_q - STEP;
          st   <= S_VEC;
        end
        S_VEC: st <= S_IDLE;
        S_POP_SR: if (stk_rd_ready_i) st <= S_WAIT_SR;
        S_WAIT_SR: if (stk_rsp_valid_i) begin
          sp_q <= sp_q + STEP;
          st   <= S_POP_PC;
        end
        S_POP_PC: if (stk_rd_ready_i) st <= S_WAIT_PC;
        S_WAIT_PC: if (stk_rsp_valid_i) begin
          sp_q <= sp_q + STEP;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign vec_idx = (st == S_RST) ? RST_IDX : idx_q;

  always_comb begin
    busy_o         = (st != S_IDLE);
    vec_fetch_o    = (st == S_VEC) || (st == S_RST);
    vec_addr_o     = VEC_BASE + (W'(vec_idx) << 1);
    sr_wr_o        = 1'b0;
    sr_wr_data_o   = '0;
    pc_wr_o        = (st == S_WAIT_PC) && stk_rsp_valid_i;
    pc_wr_data_o   = stk_rsp_data_i;
    stk_wr_valid_o = (st == S_PUSH_PC) || (st == S_PUSH_SR);
    stk_wr_addr_o  = sp_q - STEP;
    stk_wr_data_o  = (st == S_PUSH_PC) ? pc_q : sr_q;
    stk_rd_valid_o = (st == S_POP_SR) || (st == S_POP_PC);
    stk_rd_addr_o  = sp_q;
    case (st)
      S_RST: sr_wr_o = 1'b1;
      S_VEC: begin
        sr_wr_o      = 1'b1;
        sr_wr_data_o = sr_q & ~GIE_M;
      end
      S_WAIT_SR: begin
        sr_wr_o      = stk_rsp_valid_i;
        sr_wr_data_o = stk_rsp_data_i;
      end
      default: ;
    endcase
  end

  assign sp_o = sp_q;

  // R4: a stalled stack write keeps valid, address and data steady
  a_r4_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_wr_valid_o && !stk_wr_ready_i) |=>
      (stk_wr_valid_o && $stable(stk_wr_addr_o) && $stable(stk_wr_data_o)));

  // R6: a stalled read request keeps its address steady
  a_r6_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_rd_valid_o && !stk_rd_ready_i) |=> (stk_rd_valid_o && $stable(stk_rd_addr_o)));

  // R4: the stack pointer only ever moves by one slot per cycle
  a_r4_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_q != $past(sp_q)) |-> ((sp_q == $past(sp_q) - STEP) || (sp_q == $past(sp_q) + STEP)));

  // R5: every vector fetch is paired with a status load that drops the global enable
  a_r5_vec_sr: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fetch_o |-> (sr_wr_o && !sr_wr_data_o[GIE_BIT]));

  // R9: a return seen when idle always starts the pop sequence
  a_r9_reti_first: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_IDLE) && reti_req_i) |=> stk_rd_valid_o);

  // R7: the reset vector load never writes the stack
  a_r7_no_stack: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RST) |-> (!stk_wr_valid_o && sp_q == SP_INIT));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int NUM_SRC = 31,
  parameter int W = 16,
  parameter logic [W-1:0] VEC_BASE = 'hFFC0,
  parameter logic [W-1:0] SP_INIT = 'h0200,
  parameter int GIE_BIT = 3,
  parameter logic [NUM_SRC-1:0] NMI_MASK = 31'h4000_0000,
  parameter logic [NUM_SRC-1:0] AUTO_CLR_MASK = 31'h4400_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_set_i,
  input  logic [NUM_SRC-1:0] irq_clr_i,
  input  logic [NUM_SRC-1:0] irq_en_i,
  output logic [NUM_SRC-1:0] irq_flags_o,
  input  logic [W-1:0]       cpu_pc_i,
  input  logic [W-1:0]       cpu_sr_i,
  input  logic               cpu_boundary_i,
  input  logic               reti_req_i,
  output logic               busy_o,
  output logic               vec_fetch_o,
  output logic [W-1:0]       vec_addr_o,
  output logic               sr_wr_o,
  output logic [W-1:0]       sr_wr_data_o,
  output logic               pc_wr_o,
  output logic [W-1:0]       pc_wr_data_o,
  output logic [W-1:0]       sp_o,
  output logic               stk_wr_valid_o,
  input  logic               stk_wr_ready_i,
  output logic [W-1:0]       stk_wr_addr_o,
  output logic [W-1:0]       stk_wr_data_o,
  output logic               stk_rd_valid_o,
  input  logic               stk_rd_ready_i,
  output logic [W-1:0]       stk_rd_addr_o,
  input  logic               stk_rsp_valid_i,
  input  logic [W-1:0]       stk_rsp_data_i
);

  localparam int IW = $clog2(NUM_SRC + 1);

  logic          req_any;
  logic [IW-1:0] win;
  logic          ack;
  logic [IW-1:0] ack_idx;

  assign ack_idx = win;

  irq_flag_bank #(
    .N(NUM_SRC), .IW(IW), .AUTO_CLR(AUTO_CLR_MASK)
  ) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set_i(irq_set_i), .clr_i(irq_clr_i),
    .ack_i(ack), .ack_idx_i(ack_idx),
    .flags_o(irq_flags_o)
  );

  irq_prio_arb #(
    .N(NUM_SRC), .IW(IW), .NMI(NMI_MASK)
  ) u_arb (
    .clk(clk), .rst_n(rst_n),
    .flags_i(irq_flags_o), .en_i(irq_en_i),
    .gie_i(cpu_sr_i[GIE_BIT]),
    .req_any_o(req_any), .win_o(win)
  );

  irq_stack_fsm #(
    .W(W), .IW(IW), .NUM_SRC(NUM_SRC), .VEC_BASE(VEC_BASE),
    .SP_INIT(SP_INIT), .GIE_BIT(GIE_BIT)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_any_i(req_any), .win_i(win), .ack_o(ack),
    .cpu_pc_i(cpu_pc_i), .cpu_sr_i(cpu_sr_i),
    .cpu_boundary_i(cpu_boundary_i), .reti_req_i(reti_req_i),
    .busy_o(busy_o),
    .vec_fetch_o(vec_fetch_o), .vec_addr_o(vec_addr_o),
    .sr_wr_o(sr_wr_o), .sr_wr_data_o(sr_wr_data_o),
    .pc_wr_o(pc_wr_o), .pc_wr_data_o(pc_wr_data_o),
    .sp_o(sp_o),
    .stk_wr_valid_o(stk_wr_valid_o), .stk_wr_ready_i(stk_wr_ready_i),
    .stk_wr_addr_o(stk_wr_addr_o), .stk_wr_data_o(stk_wr_data_o),
    .stk_rd_valid_o(stk_rd_valid_o), .stk_rd_ready_i(stk_rd_ready_i),
    .stk_rd_addr_o(stk_rd_addr_o),
    .stk_rsp_valid_i(stk_rsp_valid_i), .stk_rsp_data_i(stk_rsp_data_i)
  );

  // R10: an entry is only accepted at a boundary while nothing runs
  a_r10_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (cpu_boundary_i && !busy_o));

endmodule

// File: tb/irq_entry_seq_tb_top.sv
module irq_entry_seq_tb_top;
  localparam int N = 31;
  localparam int W = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n;
  logic [N-1:0] irq_set_i, irq_clr_i, irq_en_i, irq_flags_o;
  logic [W-1:0] cpu_pc_i, cpu_sr_i;
  logic         cpu_boundary_i, reti_req_i, busy_o;
  logic         vec_fetch_o, sr_wr_o, pc_wr_o;
  logic [W-1:0] vec_addr_o, sr_wr_data_o, pc_wr_data_o, sp_o;
  logic         stk_wr_valid_o, stk_wr_ready_i, stk_rd_valid_o, stk_rd_ready_i;
  logic [W-1:0] stk_wr_addr_o, stk_wr_data_o, stk_rd_addr_o;
  logic         stk_rsp_valid_i;
  logic [W-1:0] stk_rsp_data_i;

  irq_entry_seq dut_i (.*);

  int errors = 0;
  int checks = 0;

  // observation state kept by the memory/core model
  logic [W-1:0] mem [0:255];
  int vec_cnt = 0, pcw_cnt = 0, srw_cnt = 0, wr_cnt = 0, seq = 0;
  int vec_seq = 0, pcw_seq = 0;
  logic [W-1:0] last_vec = '0, last_srw = '0;
  logic [W-1:0] wa_last = '0, wd_last = '0, wa_prev = '0, wd_prev = '0;
  logic         rsp_pend = 1'b0;
  logic [W-1:0] rsp_addr = '0;
  int tick = 0;

  function automatic bit is_auto(input int s);
    return (s == 26) || (s == 30);
  endfunction

  function automatic bit is_nmi(input int s);
    return s == 30;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // memory and core model, with back-pressure on both stack ports
  initial begin
    stk_wr_ready_i  = 1'b0;
    stk_rd_ready_i  = 1'b0;
    stk_rsp_valid_i = 1'b0;
    stk_rsp_data_i  = '0;
    forever begin
      @(negedge clk);
      tick++;
      stk_wr_ready_i = (tick % 3) != 1;
      stk_rd_ready_i = (tick % 4) != 2;
      if (rsp_pend) begin
        stk_rsp_valid_i = 1'b1;
        stk_rsp_data_i  = mem[rsp_addr[8:1]];
        rsp_pend        = 1'b0;
      end else begin
        stk_rsp_valid_i = 1'b0;
      end
      #1;
      if (rst_n) begin
        if (stk_wr_valid_o && stk_wr_ready_i) begin
          mem[stk_wr_addr_o[8:1]] = stk_wr_data_o;
          wa_prev = wa_last; wd_prev = wd_last;
          wa_last = stk_wr_addr_o; wd_last = stk_wr_data_o;
          wr_cnt++;
        end
        if (stk_rd_valid_o && stk_rd_ready_i) begin
          rsp_pend = 1'b1;
          rsp_addr = stk_rd_addr_o;
        end
        if (sr_wr_o) begin
          cpu_sr_i = sr_wr_data_o;
          last_srw = sr_wr_data_o;
          srw_cnt++;
        end
        if (pc_wr_o) begin
          cpu_pc_i = pc_wr_data_o;
          pcw_cnt++; seq++; pcw_seq = seq;
        end
        if (vec_fetch_o) begin
          last_vec = vec_addr_o;
          vec_cnt++; seq++; vec_seq = seq;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  task automatic pulse_set(input logic [N-1:0] m);
    irq_set_i = m;
    @(negedge clk);
    irq_set_i = '0;
  endtask

  task automatic pulse_clr(input logic [N-1:0] m);
    irq_clr_i = m;
    @(negedge clk);
    irq_clr_i = '0;
  endtask

  task automatic do_reti();
    reti_req_i = 1'b1;
    @(negedge clk);
    reti_req_i = 1'b0;
  endtask

  task automatic wait_vec(input int start, input string tag);
    for (int k = 0; k < 200 && vec_cnt == start; k++) @(negedge clk);
    chk(tag, vec_cnt, start + 1);
  endtask

  task automatic wait_pcw(input int start, input string tag);
    for (int k = 0; k < 200 && pcw_cnt == start; k++) @(negedge clk);
    chk(tag, pcw_cnt, start + 1);
  endtask

  initial begin
    int v0, p0;
    logic [W-1:0] sr_v, pc_v;
    rst_n = 1'b0;
    irq_set_i = '0; irq_clr_i = '0; irq_en_i = '0;
    cpu_pc_i = '0; cpu_sr_i = '0;
    cpu_boundary_i = 1'b1; reti_req_i = 1'b0;
    for (int a = 0; a < 256; a++) mem[a] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7: reset vector, fixed status, no stacking
    chk("R7 reset vec count", vec_cnt, 1);
    chk("R7 reset vec addr", last_vec, 16'hFFFE);
    chk("R7 reset sr value", last_srw, 16'h0000);
    chk("R7 reset no stack write", wr_cnt, 0);
    chk("R7 reset sp", sp_o, 16'h0200);
    chk("R7 idle after reset", busy_o, 1'b0);
    chk("R7 flags clear", irq_flags_o, '0);

    // R1 R2 R4 R5 R6 R8: each source alone, global enable off and on
    for (int i = 0; i < N; i++) begin
      for (int g = 0; g < 2; g++) begin
        sr_v = (g == 1) ? 16'h0108 : 16'h0100;
        pc_v = 16'h4000 + 16'(i * 4);
        cpu_sr_i = sr_v; cpu_pc_i = pc_v;
        irq_en_i = N'(1) << i;
        v0 = vec_cnt;
        pulse_set(N'(1) << i);
        if (g == 1 || is_nmi(i)) begin
          wait_vec(v0, "R1/R2 entry taken");
          chk("R5 vector address", last_vec, 16'hFFC0 + 16'(2 * i));
          chk("R5 sr with GIE dropped", last_srw, sr_v & 16'hFFF7);
          chk("R4 pc slot addr", wa_prev, 16'h01FE);
          chk("R4 pc slot data", wd_prev, pc_v);
          chk("R4 sr slot addr", wa_last, 16'h01FC);
          chk("R4 sr slot data", wd_last, sr_v);
          chk("R4 sp after entry", sp_o, 16'h01FC);
          chk("R8 flag after accept", irq_flags_o[i], is_auto(i) ? 1'b0 : 1'b1);
          pulse_clr('1);
          cpu_pc_i = 16'hDEAD;
          p0 = pcw_cnt;
          do_reti();
          wait_pcw(p0, "R6 return done");
          @(negedge clk);
          chk("R6 pc restored", cpu_pc_i, pc_v);
          chk("R6 sr restored", cpu_sr_i, sr_v);
          chk("R6 sp restored", sp_o, 16'h0200);
        end else begin
          repeat (8) @(negedge clk);
          chk("R1 masked not taken", vec_cnt, v0);
          chk("R1 masked flag held", irq_flags_o[i], 1'b1);
          pulse_clr('1);
        end
        irq_en_i = '0;
      end
    end

    // R3: every pair raised together, higher index wins
    for (int a = 0; a < N - 1; a++) begin
      for (int b = a + 1; b < N; b++) begin
        cpu_sr_i = 16'h0008; cpu_pc_i = 16'h1234;
        irq_en_i = (N'(1) << a) | (N'(1) << b);
        v0 = vec_cnt;
        pulse_set((N'(1) << a) | (N'(1) << b));
        wait_vec(v0, "R3 pair entry");
        chk("R3 winner vector", last_vec, 16'hFFC0 + 16'(2 * b));
        chk("R3 loser pending", irq_flags_o[a], 1'b1);
        pulse_clr('1);
        p0 = pcw_cnt;
        do_reti();
        wait_pcw(p0, "R3 pair return");
        irq_en_i = '0;
        @(negedge clk);
      end
    end

    // R8: set and clear together keep the flag
    irq_set_i = N'(1) << 12; irq_clr_i = N'(1) << 12;
    @(negedge clk);
    irq_set_i = '0; irq_clr_i = '0;
    chk("R8 set beats clear", irq_flags_o[12], 1'b1);
    pulse_clr(N'(1) << 12);
    chk("R8 software clear", irq_flags_o[12], 1'b0);

    // R10: no boundary, no entry
    cpu_sr_i = 16'h0008; cpu_pc_i = 16'h2000;
    cpu_boundary_i = 1'b0;
    irq_en_i = (N'(1) << 4) | (N'(1) << 7);
    v0 = vec_cnt;
    pulse_set(N'(1) << 4);
    repeat (8) @(negedge clk);
    chk("R10 held off by boundary", vec_cnt, v0);
    cpu_boundary_i = 1'b1;
    wait_vec(v0, "R10 taken at boundary");
    chk("R10 vector", last_vec, 16'hFFC8);
    // R10: request inside handler waits for the return
    v0 = vec_cnt;
    cpu_pc_i = 16'h2100;
    pulse_set(N'(1) << 7);
    repeat (8) @(negedge clk);
    chk("R10 waits in handler", vec_cnt, v0);
    pulse_clr(N'(1) << 4);
    p0 = pcw_cnt;
    do_reti();
    wait_pcw(p0, "R10 return");
    wait_vec(v0, "R10 taken after return");
    chk("R10 vector after return", last_vec, 16'hFFCE);
    chk("R10 frame at top", wa_prev, 16'h01FE);
    chk("R10 pushed restored pc", wd_prev, 16'h2000);
    pulse_clr('1);
    p0 = pcw_cnt;
    do_reti();
    wait_pcw(p0, "R10 final return");
    irq_en_i = '0;
    @(negedge clk);

    // R11: nesting after the handler re-enables
    cpu_sr_i = 16'h0008; cpu_pc_i = 16'h3000;
    irq_en_i = (N'(1) << 3) | (N'(1) << 10);
    v0 = vec_cnt;
    pulse_set(N'(1) << 3);
    wait_vec(v0, "R11 outer entry");
    pulse_clr(N'(1) << 3);
    cpu_sr_i = cpu_sr_i | 16'h0008;
    cpu_pc_i = 16'h5555;
    v0 = vec_cnt;
    pulse_set(N'(1) << 10);
    wait_vec(v0, "R11 inner entry");
    chk("R11 inner vector", last_vec, 16'hFFD4);
    chk("R11 inner frame pc addr", wa_prev, 16'h01FA);
    chk("R11 inner frame pc data", wd_prev, 16'h5555);
    chk("R11 sp two frames", sp_o, 16'h01F8);
    pulse_clr('1);
    p0 = pcw_cnt;
    do_reti();
    wait_pcw(p0, "R11 inner return");
    @(negedge clk);
    chk("R11 inner pc restored", cpu_pc_i, 16'h5555);
    chk("R11 gie back on", cpu_sr_i[3], 1'b1);
    chk("R11 sp one frame", sp_o, 16'h01FC);
    p0 = pcw_cnt;
    do_reti();
    wait_pcw(p0, "R11 outer return");
    @(negedge clk);
    chk("R11 outer pc restored", cpu_pc_i, 16'h3000);
    chk("R11 sp empty", sp_o, 16'h0200);
    irq_en_i = '0;

    // R9: return and a new non-maskable request in the same idle cycle
    cpu_sr_i = 16'h0008; cpu_pc_i = 16'h6000;
    irq_en_i = (N'(1) << 5) | (N'(1) << 30);
    v0 = vec_cnt;
    pulse_set(N'(1) << 5);
    wait_vec(v0, "R9 handler entry");
    pulse_clr(N'(1) << 5);
    v0 = vec_cnt; p0 = pcw_cnt;
    irq_set_i = N'(1) << 30;
    @(negedge clk);
    irq_set_i = '0;
    reti_req_i = 1'b1;
    @(negedge clk);
    reti_req_i = 1'b0;
    wait_pcw(p0, "R9 return ran");
    wait_vec(v0, "R9 request ran");
    chk("R9 return before entry", (pcw_seq < vec_seq) ? 1 : 0, 1);
    chk("R9 nmi vector", last_vec, 16'hFFFC);
    chk("R9 frame at top", wa_prev, 16'h01FE);
    chk("R9 pushed restored pc", wd_prev, 16'h6000);
    chk("R9 pushed restored sr", wd_last, 16'h0008);
    p0 = pcw_cnt;
    do_reti();
    wait_pcw(p0, "R9 final return");
    @(negedge clk);
    chk("R9 sp empty", sp_o, 16'h0200);

    finish_up();
  end

endmodule